// File: doc/BRIEF.md
# Asynchronous Serial Transceiver with Guard Gap and Idle Timeout

This block is a full-duplex asynchronous serial port. It sends and receives character frames over a single transmit pin and a single receive pin. A divider derives a tick at sixteen times the bit rate from the system clock. Each direction has one holding register in front of one shift register. The host can therefore write the next character while the current one is still leaving, and one received character can wait while the next one arrives.

The configuration inputs are treated as static register contents. They set the character length, the stop length, the parity mode, the pin polarity, the idle gap the transmitter leaves after every frame, and the idle time after the last received frame that raises a timeout flag. A break input forces the transmit line to the space level. The receiver takes a majority vote at the middle of each bit and rejects glitches that look like start bits. It reports parity errors, framing errors and overrun as separate flags. The host reads through a byte-wide port with a read strobe. That strobe also clears all receive flags.

Top module: `uart_guard_tmo`

## Requirements
- R1: After reset the transmit pin is at the idle level, `tx_ready` is 1, and `rx_valid` and all five receive flags are 0.
- R2: `cfg_len` selects 5, 6, 7 or 8 data bits for codes 0, 1, 2 and 3. Bits are sent least significant first. Written bits above the selected length are not sent, and received characters are returned right-aligned with the upper bits zero.
- R3: `cfg_par` code 1 selects even parity and code 2 selects odd parity. Codes 0 and 3 select no parity. The parity bit follows the last data bit, and together with the data bits it makes the count of ones even (code 1) or odd (code 2).
- R4: `cfg_stop` code 0 gives 1 stop bit, code 1 gives 1.5 stop bits (24 ticks) and codes 2 and 3 give 2 stop bits. With back-to-back characters the start-to-start spacing is 16 ticks per start, data and parity bit, plus the stop ticks.
- R5: After each frame the transmitter keeps the line idle for `cfg_guard` bit periods (16 ticks each) before the next start bit. A value of 0 adds no gap.
- R6: When `cfg_tmo` is nonzero and the receive line stays idle for `cfg_tmo` bit periods after a completed frame, `rx_timeout` is set once. A value of 0 never sets it.
- R7: While `cfg_brk` is 1, the transmit line is held at the space level (logical 0). With `cfg_inv` at 0 the pin then reads 0.
- R8: With `cfg_inv` at 1 both pins are inverted: the idle level on the pins is 0, and a loop from the transmit pin to the receive pin still delivers characters correctly.
- R9: A low level on the receive line that is no longer low when bits 7 to 9 of the start bit are sampled sets `err_false_start`. It delivers no character.
- R10: A received parity bit that does not match the selected parity sets `err_parity`, and the character is still delivered.
- R11: A stop bit sampled low sets `err_frame`, and the character is still delivered.
- R12: A frame that completes while `rx_valid` is still 1 sets `err_overrun`. The new character is dropped and `rd_data` keeps the unread one. A `rd_en` pulse clears `rx_valid` and all receive flags.
- R13: A written character moves to the shift register within one tick when the transmitter is free. `tx_ready` then returns to 1 while that frame is still in progress, so a second write is accepted and sent directly after the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_div | input | DIV_W | Tick divider: one 16x tick every cfg_div+1 clocks |
| cfg_len | input | 2 | Data length code (0..3 = 5..8 bits) |
| cfg_stop | input | 2 | Stop length code (0 = 1, 1 = 1.5, 2/3 = 2 bits) |
| cfg_par | input | 2 | Parity code (1 even, 2 odd, else none) |
| cfg_inv | input | 1 | Invert both line pins |
| cfg_guard | input | GUARD_W | Idle bit periods inserted after each sent frame |
| cfg_tmo | input | GUARD_W | Receive idle timeout in bit periods, 0 disables |
| cfg_brk | input | 1 | Force transmit line to space |
| wr_en | input | 1 | Write strobe for the transmit holding register |
| wr_data | input | 8 | Character to send |
| tx_ready | output | 1 | Transmit holding register empty |
| rd_en | input | 1 | Read strobe, clears valid and receive flags |
| rd_data | output | 8 | Received character |
| rx_valid | output | 1 | Receive holding register full |
| err_parity | output | 1 | Parity mismatch on the held character |
| err_frame | output | 1 | Stop bit sampled low |
| err_overrun | output | 1 | Frame dropped because the holding register was full |
| err_false_start | output | 1 | Start bit rejected at mid-bit |
| rx_timeout | output | 1 | Receive line idle past the timeout |
| tx_pin | output | 1 | Transmit line |
| rx_pin | input | 1 | Receive line |

## Verification
The bench builds the block with a 4-bit divider width and the default 7-bit guard and timeout width, and it runs a divider setting of 1. One bit period is then 32 clocks. A full frame with a guard gap, the 1.5-stop case and a multi-bit timeout all fit in a few hundred cycles, which makes start-to-start spacing exact and cheap to measure. A bench-side mux switches the receive pin between a loop from the transmit pin and a bit-banged driver. The driver makes parity errors, bad stop bits and short start glitches, which the transmitter alone can never produce.

// File: rtl/uart_gt_pkg.sv
package uart_gt_pkg;

  typedef enum logic [2:0] {
    PH_IDLE, PH_START, PH_DATA, PH_PAR, PH_STOP, PH_GUARD
  } phase_t;

  // Mask of live data bits for a length code (0..3 -> 5..8 bits)
  function automatic logic [7:0] len_mask(input logic [1:0] len);
    return 8'hFF >> (2'd3 - len);
  endfunction

  // Index of the last data bit for a length code
  function automatic logic [2:0] last_bit(input logic [1:0] len);
    return {1'b1, len};
  endfunction

  function automatic logic par_on(input logic [1:0] mode);
    return (mode == 2'd1) || (mode == 2'd2);
  endfunction

  function automatic logic par_odd(input logic [1:0] mode);
    return mode == 2'd2;
  endfunction

  // Stop field length in 16x ticks
  function automatic logic [5:0] stop_ticks(input logic [1:0] code);
    case (code)
      2'd0:    return 6'd16;
      2'd1:    return 6'd24;
      default: return 6'd32;
    endcase
  endfunction

endpackage

// File: rtl/uart_gt_tick.sv
module uart_gt_tick #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d;

  assign tick = (cnt_q == div);

  always_comb begin
    cnt_d = tick ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/uart_gt_tx.sv
module uart_gt_tx
  import uart_gt_pkg::*;
#(
  parameter int GUARD_W = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic [1:0]         len,
  input  logic [1:0]         stop,
  input  logic [1:0]         par,
  input  logic [GUARD_W-1:0] guard,
  input  logic               brk,
  input  logic               inv,
  input  logic               wr_en,
  input  logic [7:0]         wr_data,
  output logic               ready,
  output logic               pin
);
  localparam int CNT_W = GUARD_W + 4;
  localparam logic [CNT_W-1:0] BIT_END = CNT_W'(15);

  phase_t           st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [2:0]       bit_q, bit_d;
  logic [7:0]       sh_q, sh_d, hold_q, hold_d;
  logic             pb_q, pb_d, full_q, full_d;
  logic             done, line;
  logic [CNT_W-1:0] stop_end, guard_end;

  assign stop_end  = CNT_W'(stop_ticks(stop)) - 1'b1;
  assign guard_end = {guard, 4'b0000} - 1'b1;
  assign ready     = !full_q;

  always_comb begin
    st_d = st_q; cnt_d = cnt_q; bit_d = bit_q; sh_d = sh_q;
    pb_d = pb_q; hold_d = hold_q; full_d = full_q; done = 1'b0;
    if (tick) begin
      cnt_d = cnt_q + 1'b1;
      case (st_q)
        PH_START: if (cnt_q == BIT_END) begin
          st_d = PH_DATA; cnt_d = '0; bit_d = '0;
        end
        PH_DATA: if (cnt_q == BIT_END) begin
          cnt_d = '0;
          sh_d  = sh_q >> 1;
          if (bit_q == last_bit(len)) st_d = par_on(par) ? PH_PAR : PH_STOP;
          else                        bit_d = bit_q + 1'b1;
        end
        PH_PAR: if (cnt_q == BIT_END) begin
          st_d = PH_STOP; cnt_d = '0;
        end
        PH_STOP: if (cnt_q == stop_end) begin
          cnt_d = '0;
          if (guard != '0) st_d = PH_GUARD;
          else begin st_d = PH_IDLE; done = 1'b1; end
        end
        PH_GUARD: if (cnt_q == guard_end) begin
          cnt_d = '0; st_d = PH_IDLE; done = 1'b1;
        end
        default: begin cnt_d = '0; done = 1'b1; end
      endcase
    end
    // Launch the held character straight from the end of the previous frame
    if (done && full_q) begin
      st_d   = PH_START;
      cnt_d  = '0;
      sh_d   = hold_q;
      pb_d   = (^(hold_q & len_mask(len))) ^ par_odd(par);
      full_d = 1'b0;
    end
    if (wr_en && !full_q) begin
      hold_d = wr_data;
      full_d = 1'b1;
    end
  end

  always_comb begin
    case (st_q)
      PH_START: line = 1'b0;
      PH_DATA:  line = sh_q[0];
      PH_PAR:   line = pb_q;
      default:  line = 1'b1;
    endcase
    pin = (brk ? 1'b0 : line) ^ inv;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= PH_IDLE; cnt_q <= '0; bit_q <= '0; sh_q <= '0;
      pb_q <= 1'b0; hold_q <= '0; full_q <= 1'b0;
    end else begin
      st_q <= st_d; cnt_q <= cnt_d; bit_q <= bit_d; sh_q <= sh_d;
      pb_q <= pb_d; hold_q <= hold_d; full_q <= full_d;
    end
  end
endmodule

// File: rtl/uart_gt_rx.sv
module uart_gt_rx
  import uart_gt_pkg::*;
#(
  parameter int GUARD_W = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic [1:0]         len,
  input  logic [1:0]         par,
  input  logic [GUARD_W-1:0] tmo,
  input  logic               inv,
  input  logic               rd_en,
  input  logic               pin,
  output logic [7:0]         rd_data,
  output logic               valid,
  output logic               e_par,
  output logic               e_frm,
  output logic               e_ovr,
  output logic               e_fs,
  output logic               e_tmo
);
  localparam int CNT_W = GUARD_W + 4;

  phase_t           st_q, st_d;
  logic [3:0]       cnt_q, cnt_d;
  logic [2:0]       bit_q, bit_d;
  logic [7:0]       sh_q, sh_d, dat_q, dat_d, data_now;
  logic [CNT_W-1:0] tc_q, tc_d, tgt;
  logic [1:0]       sync_q;
  logic v7_q, v7_d, v8_q, v8_d, bv_q, bv_d, pb_q, pb_d, arm_q, arm_d;
  logic val_q, val_d, par_q, par_d, frm_q, frm_d, ovr_q, ovr_d;
  logic fs_q, fs_d, tmo_q, tmo_d;
  logic line, maj, exp_p;

  assign line     = sync_q[1] ^ inv;
  assign maj      = (v7_q & v8_q) | (v7_q & line) | (v8_q & line);
  assign data_now = sh_q >> (2'd3 - len);
  assign exp_p    = (^data_now) ^ par_odd(par);
  assign tgt      = {tmo, 4'b0000} - 1'b1;

  always_comb begin
    st_d = st_q; cnt_d = cnt_q; bit_d = bit_q; sh_d = sh_q; dat_d = dat_q;
    tc_d = tc_q; v7_d = v7_q; v8_d = v8_q; bv_d = bv_q; pb_d = pb_q;
    arm_d = arm_q; val_d = val_q; par_d = par_q; frm_d = frm_q;
    ovr_d = ovr_q; fs_d = fs_q; tmo_d = tmo_q;
    if (rd_en) begin
      val_d = 1'b0; par_d = 1'b0; frm_d = 1'b0;
      ovr_d = 1'b0; fs_d = 1'b0; tmo_d = 1'b0;
    end
    if (tick) begin
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == 4'd7) v7_d = line;
      if (cnt_q == 4'd8) v8_d = line;
      if (cnt_q == 4'd9) bv_d = maj;
      case (st_q)
        PH_START:
          if (cnt_q == 4'd9 && maj) begin
            fs_d = 1'b1; st_d = PH_IDLE;
          end else if (cnt_q == 4'd15) begin
            st_d = PH_DATA; cnt_d = '0; bit_d = '0;
          end
        PH_DATA: if (cnt_q == 4'd15) begin
          cnt_d = '0;
          sh_d  = {bv_q, sh_q[7:1]};
          if (bit_q == last_bit(len)) st_d = par_on(par) ? PH_PAR : PH_STOP;
          else                        bit_d = bit_q + 1'b1;
        end
        PH_PAR: if (cnt_q == 4'd15) begin
          pb_d = bv_q; st_d = PH_STOP; cnt_d = '0;
        end
        PH_STOP: if (cnt_q == 4'd9) begin
          st_d = PH_IDLE; arm_d = 1'b1; tc_d = '0;
          if (val_q && !rd_en) ovr_d = 1'b1;
          else begin
            dat_d = data_now; val_d = 1'b1;
            par_d = par_on(par) && (pb_q != exp_p);
            frm_d = !maj;
          end
        end
        default: begin
          cnt_d = '0;
          if (!line) begin
            st_d = PH_START; arm_d = 1'b0;
          end else if (arm_q) begin
            if (tmo != '0 && tc_q >= tgt) begin
              tmo_d = 1'b1; arm_d = 1'b0;
            end else if (tc_q != '1) tc_d = tc_q + 1'b1;
          end
        end
      endcase
    end
  end

  assign rd_data = dat_q;
  assign valid   = val_q;
  assign e_par   = par_q;
  assign e_frm   = frm_q;
  assign e_ovr   = ovr_q;
  assign e_fs    = fs_q;
  assign e_tmo   = tmo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b11;
      st_q <= PH_IDLE; cnt_q <= '0; bit_q <= '0; sh_q <= '0; dat_q <= '0;
      tc_q <= '0; v7_q <= 1'b1; v8_q <= 1'b1; bv_q <= 1'b1; pb_q <= 1'b0;
      arm_q <= 1'b0; val_q <= 1'b0; par_q <= 1'b0; frm_q <= 1'b0;
      ovr_q <= 1'b0; fs_q <= 1'b0; tmo_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], pin};
      st_q <= st_d; cnt_q <= cnt_d; bit_q <= bit_d; sh_q <= sh_d; dat_q <= dat_d;
      tc_q <= tc_d; v7_q <= v7_d; v8_q <= v8_d; bv_q <= bv_d; pb_q <= pb_d;
      arm_q <= arm_d; val_q <= val_d; par_q <= par_d; frm_q <= frm_d;
      ovr_q <= ovr_d; fs_q <= fs_d; tmo_q <= tmo_d;
    end
  end
endmodule

// File: rtl/uart_guard_tmo.sv
module uart_guard_tmo #(
  parameter int DIV_W   = 16,
  parameter int GUARD_W = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [DIV_W-1:0]   cfg_div,
  input  logic [1:0]         cfg_len,
  input  logic [1:0]         cfg_stop,
  input  logic [1:0]         cfg_par,
  input  logic               cfg_inv,
  input  logic [GUARD_W-1:0] cfg_guard,
  input  logic [GUARD_W-1:0] cfg_tmo,
  input  logic               cfg_brk,
  input  logic               wr_en,
  input  logic [7:0]         wr_data,
  output logic               tx_ready,
  input  logic               rd_en,
  output logic [7:0]         rd_data,
  output logic               rx_valid,
  output logic               err_parity,
  output logic               err_frame,
  output logic               err_overrun,
  output logic               err_false_start,
  output logic               rx_timeout,
  output logic               tx_pin,
  input  logic               rx_pin
);
  logic [1:0] rst_sync_q;
  logic       rst_n_int;
  logic       tick;

  // Assert asynchronously, release on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  uart_gt_tick #(.DIV_W(DIV_W)) tick_i (
    .clk(clk), .rst_n(rst_n_int), .div(cfg_div), .tick(tick)
  );

  uart_gt_tx #(.GUARD_W(GUARD_W)) tx_i (
    .clk(clk), .rst_n(rst_n_int), .tick(tick), .len(cfg_len), .stop(cfg_stop),
    .par(cfg_par), .guard(cfg_guard), .brk(cfg_brk), .inv(cfg_inv),
    .wr_en(wr_en), .wr_data(wr_data), .ready(tx_ready), .pin(tx_pin)
  );

  uart_gt_rx #(.GUARD_W(GUARD_W)) rx_i (
    .clk(clk), .rst_n(rst_n_int), .tick(tick), .len(cfg_len), .par(cfg_par),
    .tmo(cfg_tmo), .inv(cfg_inv), .rd_en(rd_en), .pin(rx_pin),
    .rd_data(rd_data), .valid(rx_valid), .e_par(err_parity), .e_frm(err_frame),
    .e_ovr(err_overrun), .e_fs(err_false_start), .e_tmo(rx_timeout)
  );
endmodule

// File: rtl/uart_guard_tmo_chk.sv
module uart_guard_tmo_chk #(
  parameter int GUARD_W = 7
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cfg_brk,
  input logic               cfg_inv,
  input logic [GUARD_W-1:0] cfg_tmo,
  input logic               tx_pin,
  input logic               wr_en,
  input logic               tx_ready,
  input logic               rd_en,
  input logic               rx_valid,
  input logic [7:0]         rd_data,
  input logic               err_overrun,
  input logic               rx_timeout
);
  AST_BREAK_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_brk |-> (tx_pin == cfg_inv)); // R7

  AST_TMO_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_tmo == '0 && !rx_timeout) |=> !rx_timeout); // R6

  AST_HELD_DATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rd_en) |=> $stable(rd_data)); // R12

  AST_OVERRUN_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_overrun) |-> rx_valid); // R12

  AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err_overrun && !rd_en) |=> err_overrun); // R12

  AST_WRITE_FILLS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && tx_ready) |=> !tx_ready); // R13
endmodule

bind uart_guard_tmo uart_guard_tmo_chk #(.GUARD_W(GUARD_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_brk(cfg_brk), .cfg_inv(cfg_inv),
  .cfg_tmo(cfg_tmo), .tx_pin(tx_pin), .wr_en(wr_en), .tx_ready(tx_ready),
  .rd_en(rd_en), .rx_valid(rx_valid), .rd_data(rd_data),
  .err_overrun(err_overrun), .rx_timeout(rx_timeout)
);

// File: tb/uart_guard_tmo_tb_top.sv
module uart_guard_tmo_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int BIT_CLK    = 32;   // cfg_div = 1 -> tick every 2 clocks
  localparam int DIV_W      = 4;
  localparam int GUARD_W    = 7;

  logic clk, rst_n;
  logic [DIV_W-1:0]   cfg_div;
  logic [1:0]         cfg_len, cfg_stop, cfg_par;
  logic               cfg_inv, cfg_brk;
  logic [GUARD_W-1:0] cfg_guard, cfg_tmo;
  logic wr_en, rd_en, tx_ready, rx_valid, tx_pin, rx_pin;
  logic [7:0] wr_data, rd_data;
  logic err_parity, err_frame, err_overrun, err_false_start, rx_timeout;
  logic sel_bench, bench_rx;

  int checks = 0, fails = 0, cyc = 0;
  int e_cnt = 0, e_last = 0, e_prev = 0;
  logic prev_tx = 1'b1;

  assign rx_pin = sel_bench ? bench_rx : tx_pin;

  uart_guard_tmo #(.DIV_W(DIV_W), .GUARD_W(GUARD_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_len(cfg_len),
    .cfg_stop(cfg_stop), .cfg_par(cfg_par), .cfg_inv(cfg_inv),
    .cfg_guard(cfg_guard), .cfg_tmo(cfg_tmo), .cfg_brk(cfg_brk),
    .wr_en(wr_en), .wr_data(wr_data), .tx_ready(tx_ready), .rd_en(rd_en),
    .rd_data(rd_data), .rx_valid(rx_valid), .err_parity(err_parity),
    .err_frame(err_frame), .err_overrun(err_overrun),
    .err_false_start(err_false_start), .rx_timeout(rx_timeout),
    .tx_pin(tx_pin), .rx_pin(rx_pin)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // Record the times of falling edges on the transmit pin
  always @(negedge clk) begin
    if (prev_tx && !tx_pin) begin
      e_prev = e_last;
      e_last = cyc;
      e_cnt  = e_cnt + 1;
    end
    prev_tx = tx_pin;
  end

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr_byte(input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd_byte(output logic [7:0] d);
    @(negedge clk); d = rd_data; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic wait_valid(input int max);
    for (int i = 0; i < max; i++) begin
      @(negedge clk);
      if (rx_valid) break;
    end
  endtask

  task automatic wait_edges(input int base, input int n);
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (e_cnt >= base + n) break;
    end
  endtask

  task automatic set_cfg(input logic [1:0] len, input logic [1:0] stp,
                         input logic [1:0] par, input int guard);
    @(negedge clk);
    cfg_len = len; cfg_stop = stp; cfg_par = par; cfg_guard = GUARD_W'(guard);
  endtask

  // Bit-bang one frame onto the receive pin (cfg_inv assumed 0)
  task automatic send_raw(input logic [7:0] d, input int nb, input bit has_p,
                          input logic pbit, input logic stopv);
    bench_rx = 1'b0; wait_clk(BIT_CLK);
    for (int i = 0; i < nb; i++) begin bench_rx = d[i]; wait_clk(BIT_CLK); end
    if (has_p) begin bench_rx = pbit; wait_clk(BIT_CLK); end
    bench_rx = stopv; wait_clk(BIT_CLK);
    bench_rx = 1'b1;
  endtask

  task automatic t_reset();
    chk("R1 tx idle", int'(tx_pin), 1);
    chk("R1 tx_ready", int'(tx_ready), 1);
    chk("R1 rx status", int'({rx_valid, err_parity, err_frame, err_overrun,
                               err_false_start, rx_timeout}), 0);
  endtask

  task automatic t_loop_lengths();
    logic [7:0] d;
    sel_bench = 1'b0;
    set_cfg(2'd3, 2'd0, 2'd0, 0);
    wr_byte(8'hA5); wait_valid(800); rd_byte(d);
    chk("R2 8-bit loop", int'(d), 'hA5);
    set_cfg(2'd0, 2'd0, 2'd0, 0);
    wr_byte(8'hFF); wait_valid(800); rd_byte(d);
    chk("R2 5-bit upper bits dropped", int'(d), 'h1F);
    set_cfg(2'd2, 2'd0, 2'd1, 0);
    wr_byte(8'hD5); wait_valid(800);
    chk("R3 7E1 loop no parity error", int'(err_parity), 0);
    rd_byte(d);
    chk("R2 7-bit loop", int'(d), 'h55);
    set_cfg(2'd1, 2'd0, 2'd2, 0);
    wr_byte(8'h2A); wait_valid(800);
    chk("R3 6O1 loop no parity error", int'(err_parity), 0);
    rd_byte(d);
    chk("R2 6-bit loop", int'(d), 'h2A);
  endtask

  task automatic t_rx_parity();
    logic [7:0] d;
    sel_bench = 1'b1; bench_rx = 1'b1;
    set_cfg(2'd3, 2'd0, 2'd1, 0);
    send_raw(8'h01, 8, 1'b1, 1'b0, 1'b1); wait_valid(200);
    chk("R10 even parity mismatch flagged", int'(err_parity), 1);
    rd_byte(d);
    chk("R10 data still delivered", int'(d), 'h01);
    send_raw(8'h01, 8, 1'b1, 1'b1, 1'b1); wait_valid(200);
    chk("R3 even parity accepted", int'(err_parity), 0);
    rd_byte(d);
    set_cfg(2'd3, 2'd0, 2'd2, 0);
    send_raw(8'h03, 8, 1'b1, 1'b1, 1'b1); wait_valid(200);
    chk("R3 odd parity accepted", int'(err_parity), 0);
    rd_byte(d);
  endtask

  task automatic t_tx_parity();
    int base, t0;
    sel_bench = 1'b1; bench_rx = 1'b1;
    for (int m = 1; m <= 2; m++) begin
      set_cfg(2'd3, 2'd0, 2'(m), 0);
      base = e_cnt;
      wr_byte(8'h07);
      wait_edges(base, 1);
      t0 = e_last;
      while (cyc < t0 + 9*BIT_CLK + BIT_CLK/2) @(negedge clk);
      chk(m == 1 ? "R3 tx even parity bit" : "R3 tx odd parity bit",
          int'(tx_pin), m == 1 ? 1 : 0);
      wait_clk(3*BIT_CLK);
    end
  endtask

  task automatic spacing(input logic [1:0] stp, input int guard, input int exp,
                         input string req);
    int base;
    set_cfg(2'd3, stp, 2'd0, guard);
    base = e_cnt;
    wr_byte(8'h00);
    wait_clk(6);
    chk("R13 holding free while frame runs", int'(tx_ready), 1);
    wr_byte(8'h00);
    wait_edges(base, 2);
    chk(req, e_last - e_prev, exp);
    wait_clk(12*BIT_CLK + guard*BIT_CLK);
  endtask

  task automatic t_stop_guard();
    sel_bench = 1'b1; bench_rx = 1'b1;
    spacing(2'd0, 0, 10*BIT_CLK, "R4 one stop spacing");
    spacing(2'd1, 0, 9*BIT_CLK + 48, "R4 1.5 stop spacing");
    spacing(2'd2, 0, 11*BIT_CLK, "R4 two stop spacing");
    spacing(2'd0, 3, 13*BIT_CLK, "R5 guard of 3 bits");
  endtask

  task automatic t_overrun();
    logic [7:0] d;
    sel_bench = 1'b0;
    set_cfg(2'd3, 2'd0, 2'd0, 0);
    wr_byte(8'h11);
    wait_clk(6);
    wr_byte(8'h22);
    for (int i = 0; i < 1200; i++) begin
      @(negedge clk);
      if (err_overrun) break;
    end
    chk("R12 overrun flagged", int'(err_overrun), 1);
    chk("R12 first character kept", int'(rd_data), 'h11);
    rd_byte(d);
    chk("R12 read clears valid and overrun", int'({rx_valid, err_overrun}), 0);
  endtask

  task automatic t_timeout();
    logic [7:0] d;
    sel_bench = 1'b0;
    set_cfg(2'd3, 2'd0, 2'd0, 0);
    @(negedge clk); cfg_tmo = '0;
    wr_byte(8'h5C); wait_valid(800);
    wait_clk(400);
    chk("R6 zero timeout never fires", int'(rx_timeout), 0);
    rd_byte(d);
    @(negedge clk); cfg_tmo = GUARD_W'(2);
    wait_clk(10); rd_byte(d);
    wr_byte(8'h6D); wait_valid(800);
    wait_clk(20);
    chk("R6 no timeout before gap", int'(rx_timeout), 0);
    wait_clk(100);
    chk("R6 timeout after 2 idle bits", int'(rx_timeout), 1);
    rd_byte(d);
    @(negedge clk); cfg_tmo = '0;
  endtask

  task automatic t_false_start();
    logic [7:0] d;
    sel_bench = 1'b1; bench_rx = 1'b1;
    wait_clk(10);
    bench_rx = 1'b0; wait_clk(4); bench_rx = 1'b1;
    wait_clk(100);
    chk("R9 false start flagged", int'(err_false_start), 1);
    chk("R9 no character delivered", int'(rx_valid), 0);
    rd_byte(d);
    chk("R9 read clears false start", int'(err_false_start), 0);
  endtask

  task automatic t_frame();
    logic [7:0] d;
    sel_bench = 1'b1; bench_rx = 1'b1;
    set_cfg(2'd3, 2'd0, 2'd0, 0);
    send_raw(8'h5A, 8, 1'b0, 1'b0, 1'b0);
    wait_clk(60);
    chk("R11 framing error flagged", int'(err_frame), 1);
    chk("R11 data delivered", int'(rd_data), 'h5A);
    rd_byte(d);
  endtask

  task automatic t_polarity_break();
    logic [7:0] d;
    sel_bench = 1'b1;
    @(negedge clk); cfg_brk = 1'b1;
    @(negedge clk);
    chk("R7 break drives pin low", int'(tx_pin), 0);
    cfg_brk = 1'b0;
    @(negedge clk);
    chk("R7 release returns to idle", int'(tx_pin), 1);
    @(negedge clk); cfg_inv = 1'b1; bench_rx = 1'b0;
    wait_clk(200); rd_byte(d);
    chk("R8 inverted idle level", int'(tx_pin), 0);
    sel_bench = 1'b0;
    wr_byte(8'h3C); wait_valid(800);
    chk("R8 inverted loop flags clean", int'({err_parity, err_frame}), 0);
    rd_byte(d);
    chk("R8 inverted loop data", int'(d), 'h3C);
    wait_clk(2*BIT_CLK);
    sel_bench = 1'b1;
    @(negedge clk); cfg_brk = 1'b1;
    @(negedge clk);
    chk("R7 break with inversion drives pin high", int'(tx_pin), 1);
    cfg_brk = 1'b0; cfg_inv = 1'b0; bench_rx = 1'b1;
    wait_clk(400); rd_byte(d);
  endtask

  initial begin
    rst_n = 1'b0; cfg_div = DIV_W'(1); cfg_len = 2'd3; cfg_stop = 2'd0;
    cfg_par = 2'd0; cfg_inv = 1'b0; cfg_brk = 1'b0; cfg_guard = '0;
    cfg_tmo = '0; wr_en = 1'b0; wr_data = '0; rd_en = 1'b0;
    sel_bench = 1'b1; bench_rx = 1'b1;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);
    t_reset();
    t_loop_lengths();
    t_rx_parity();
    t_tx_parity();
    t_stop_guard();
    t_overrun();
    t_timeout();
    t_false_start();
    t_frame();
    t_polarity_break();
    summary();
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; fails++;
    $display("FAIL watchdog: run did not complete");
    summary();
    $finish;
  end
endmodule